// File: doc/BRIEF.md
# SDRAM Bank State Tracker and Command Checker

This block sits beside the command bus of a four-bank single-data-rate SDRAM and follows every command the controller issues. On each rising clock edge it decodes chip select, the row strobe, the column strobe and write enable, together with the bank address and address bit A10. From these it keeps a state for every bank and a device-wide state for refresh, mode-register load and all-bank precharge.

Each command is checked against the state of the bank it targets, or against the whole device for the all-bank commands. A command that is not allowed raises a one-cycle error pulse, with the bank and a reason code, and changes no state. The row-to-column, precharge, refresh and mode-register intervals are counted in clock cycles taken from static inputs, and so is the burst length. The block is meant for verification environments and for on-chip protocol monitoring. It does not model the data path or CAS latency.

Top module: `sdram_bank_monitor`

## Requirements
- R1: COMMAND INHIBIT (cs_n high, whatever the other pins are) and NOP (cs_n low, ras_n/cas_n/we_n all high) raise no error and change no bank or device state.
- R2: ACTIVE ({ras_n,cas_n,we_n}=011) to an Idle bank puts it in Row Activating (code 1) for t_rcd cycles, and then in Row Active (code 2). A READ is legal t_rcd cycles after the ACTIVE. ACTIVE to a bank in Row Active, Read or Write gives error code 5.
- R3: READ (101) or WRITE (100) with A10 low, sent to a bank in Row Active, Read or Write, puts it in Read (code 3) or Write (code 4) for burst_len cycles, and then back in Row Active. The same command to an Idle bank gives error code 4.
- R4: READ or WRITE with A10 high puts the bank in Read-with-auto-precharge (code 6) or Write-with-auto-precharge (code 7) for burst_len+t_rp cycles, and then in Idle.
- R5: PRECHARGE (010) with A10 low, sent to an open bank, puts that bank in Precharging (code 5) for t_rp cycles and then in Idle. Sent to an Idle bank it is legal and has no effect.
- R6: BURST TERMINATE (110) to a bank in Read or Write returns it to Row Active on the next cycle. Sent to a bank in any other state it gives error code 6.
- R7: Any command to a bank in Row Activating, Precharging or an auto-precharge state gives error code 2. Other banks keep their own states and timers.
- R8: AUTO REFRESH (001) and LOAD MODE REGISTER (000) are legal only when all banks are Idle. If not, the error code is 3 and err_bank is the lowest bank that is not Idle. When legal, dev_state is 1 (refresh) for t_rfc cycles or 2 (mode) for t_mrd cycles.
- R9: PRECHARGE with A10 high closes all banks at once and holds dev_state at 3 for t_rp cycles. If any bank is in a locked state (see R7), it gives error code 2 with the lowest such bank.
- R10: While dev_state is not 0, any command other than NOP or INHIBIT gives error code 1, with err_bank equal to ba.
- R11: The error outputs register the check: err is high for exactly the cycle after an illegal command, with err_bank and err_code. An illegal command changes no bank state and no device state.
- R12: A synchronous reset (rst high) sets every bank to Idle (code 0) and dev_state to 0, and clears err, err_bank and err_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Target bank |
| a10 | input | 1 | Auto-precharge / all-bank select |
| t_rp | input | 8 | Precharge interval in cycles |
| t_rcd | input | 8 | Row-to-column interval in cycles |
| t_rfc | input | 8 | Refresh interval in cycles |
| t_mrd | input | 8 | Mode-register interval in cycles |
| burst_len | input | 8 | Burst duration in cycles |
| bank_state | output | 12 | Bank i state in bits [3i+2:3i] |
| dev_state | output | 2 | 0 normal, 1 refresh, 2 mode load, 3 precharge-all |
| err | output | 1 | Illegal-command pulse |
| err_bank | output | 2 | Bank blamed for the error |
| err_code | output | 3 | Error reason code (0 when no error) |

## Verification
The embedded properties check four things on every cycle. Any command during a device-wide busy state is reported. A rejected command leaves an Idle or open bank where it was. Legal ACTIVE and PRECHARGE commands enter their transitional states. During refresh every bank reads Idle. The exact lengths of the t_rcd, t_rp, t_rfc, t_mrd and burst windows, the choice of the lowest bank on all-bank errors, and the independence of banks whose timers overlap can only be shown by the bench's timed command sequences.

// File: rtl/sdram_bank_monitor.sv
module sdram_bank_monitor #(
  parameter int NBANK = 4,
  parameter int TW = 8,
  localparam int BW = $clog2(NBANK)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BW-1:0]        ba,
  input  logic                 a10,
  input  logic [TW-1:0]        t_rp,
  input  logic [TW-1:0]        t_rcd,
  input  logic [TW-1:0]        t_rfc,
  input  logic [TW-1:0]        t_mrd,
  input  logic [TW-1:0]        burst_len,
  output logic [3*NBANK-1:0]   bank_state,
  output logic [1:0]           dev_state,
  output logic                 err,
  output logic [BW-1:0]        err_bank,
  output logic [2:0]           err_code
);
  localparam int CW = TW + 1;

  typedef enum logic [2:0] {S_IDLE, S_ACTG, S_ACT, S_RD, S_WR, S_PRE, S_RDAP, S_WRAP} bst_t;
  typedef enum logic [1:0] {D_IDLE, D_REF, D_MRS, D_PALL} dst_t;
  typedef enum logic [2:0] {C_NOP, C_ACT, C_RD, C_WR, C_BST, C_PRE, C_REF, C_LMR} cmd_t;

  localparam logic [2:0] E_DEV = 3'd1, E_BANK = 3'd2, E_NIDLE = 3'd3,
                         E_NOROW = 3'd4, E_OPEN = 3'd5, E_BST = 3'd6;

  bst_t           st_q [NBANK];
  bst_t           st_d [NBANK];
  logic [CW-1:0]  cnt_q [NBANK];
  logic [CW-1:0]  cnt_d [NBANK];
  dst_t           dev_q, dev_d;
  logic [TW-1:0]  dcnt_q, dcnt_d;

  cmd_t           cmd;
  bst_t           tgt;
  logic           bad;
  logic [2:0]     why;
  logic [BW-1:0]  who;

  logic           ld, dld;
  bst_t           ld_tr, ld_fin;
  dst_t           dld_st;
  logic [CW-1:0]  ld_n;
  logic [TW-1:0]  dld_n;

  function automatic logic locked(bst_t s);
    return s == S_ACTG || s == S_PRE || s == S_RDAP || s == S_WRAP;
  endfunction

  always_comb begin
    if (cs_n) cmd = C_NOP;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b110:  cmd = C_BST;
        3'b010:  cmd = C_PRE;
        3'b001:  cmd = C_REF;
        3'b000:  cmd = C_LMR;
        default: cmd = C_NOP;
      endcase
    end
  end

  assign tgt = st_q[ba];

  always_comb begin
    bad = 1'b0;
    why = 3'd0;
    who = ba;
    if (cmd != C_NOP) begin
      if (dev_q != D_IDLE) begin
        bad = 1'b1; why = E_DEV;
      end else if (cmd == C_REF || cmd == C_LMR) begin
        for (int i = NBANK - 1; i >= 0; i--)
          if (st_q[i] != S_IDLE) begin bad = 1'b1; why = E_NIDLE; who = BW'(i); end
      end else if (cmd == C_PRE && a10) begin
        for (int i = NBANK - 1; i >= 0; i--)
          if (locked(st_q[i])) begin bad = 1'b1; why = E_BANK; who = BW'(i); end
      end else if (locked(tgt)) begin
        bad = 1'b1; why = E_BANK;
      end else begin
        case (cmd)
          C_ACT:      if (tgt != S_IDLE) begin bad = 1'b1; why = E_OPEN; end
          C_RD, C_WR: if (tgt == S_IDLE) begin bad = 1'b1; why = E_NOROW; end
          C_BST:      if (tgt != S_RD && tgt != S_WR) begin bad = 1'b1; why = E_BST; end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    ld = 1'b0; ld_tr = S_IDLE; ld_fin = S_IDLE; ld_n = '0;
    dld = 1'b0; dld_st = D_IDLE; dld_n = '0;
    dev_d = dev_q;
    dcnt_d = dcnt_q;
    for (int i = 0; i < NBANK; i++) begin
      st_d[i] = st_q[i];
      cnt_d[i] = cnt_q[i];
      if (st_q[i] != S_IDLE && st_q[i] != S_ACT) begin
        if (cnt_q[i] <= CW'(1))
          st_d[i] = (st_q[i] == S_ACTG || st_q[i] == S_RD || st_q[i] == S_WR) ? S_ACT : S_IDLE;
        else
          cnt_d[i] = cnt_q[i] - CW'(1);
      end
    end
    if (dev_q != D_IDLE) begin
      if (dcnt_q <= TW'(1)) dev_d = D_IDLE;
      else dcnt_d = dcnt_q - TW'(1);
    end
    if (!bad) begin
      case (cmd)
        C_ACT: begin ld = 1'b1; ld_tr = S_ACTG; ld_fin = S_ACT; ld_n = {1'b0, t_rcd}; end
        C_RD, C_WR: begin
          ld = 1'b1;
          if (a10) begin
            ld_tr = (cmd == C_RD) ? S_RDAP : S_WRAP;
            ld_fin = S_IDLE;
            ld_n = {1'b0, burst_len} + {1'b0, t_rp};
          end else begin
            ld_tr = (cmd == C_RD) ? S_RD : S_WR;
            ld_fin = S_ACT;
            ld_n = {1'b0, burst_len};
          end
        end
        C_BST: st_d[ba] = S_ACT;
        C_PRE: begin
          if (a10) begin
            for (int i = 0; i < NBANK; i++) st_d[i] = S_IDLE;
            dld = 1'b1; dld_st = D_PALL; dld_n = t_rp;
          end else if (tgt != S_IDLE) begin
            ld = 1'b1; ld_tr = S_PRE; ld_fin = S_IDLE; ld_n = {1'b0, t_rp};
          end
        end
        C_REF: begin dld = 1'b1; dld_st = D_REF; dld_n = t_rfc; end
        C_LMR: begin dld = 1'b1; dld_st = D_MRS; dld_n = t_mrd; end
        default: ;
      endcase
    end
    if (ld) begin
      if (ld_n <= CW'(1)) st_d[ba] = ld_fin;
      else begin st_d[ba] = ld_tr; cnt_d[ba] = ld_n - CW'(1); end
    end
    if (dld && dld_n > TW'(1)) begin
      dev_d = dld_st;
      dcnt_d = dld_n - TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBANK; i++) begin
        st_q[i]  <= S_IDLE;
        cnt_q[i] <= '0;
      end
      dev_q    <= D_IDLE;
      dcnt_q   <= '0;
      err      <= 1'b0;
      err_bank <= '0;
      err_code <= 3'd0;
    end else begin
      for (int i = 0; i < NBANK; i++) begin
        st_q[i]  <= st_d[i];
        cnt_q[i] <= cnt_d[i];
      end
      dev_q    <= dev_d;
      dcnt_q   <= dcnt_d;
      err      <= bad;
      err_bank <= bad ? who : '0;
      err_code <= bad ? why : 3'd0;
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_out
    assign bank_state[3*g +: 3] = st_q[g];
  end
  assign dev_state = dev_q;

  assert_devbusy_R10: assert property (@(posedge clk) disable iff (rst)
    (dev_q != D_IDLE && cmd != C_NOP) |=> (err && err_code == E_DEV));

  assert_reject_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (bad && (tgt == S_IDLE || tgt == S_ACT)) |=> (st_q[$past(ba)] == $past(tgt)));

  assert_act_enter_R2: assert property (@(posedge clk) disable iff (rst)
    (!bad && cmd == C_ACT && t_rcd > TW'(1)) |=> (st_q[$past(ba)] == S_ACTG));

  assert_pre_enter_R5: assert property (@(posedge clk) disable iff (rst)
    (!bad && cmd == C_PRE && !a10 && tgt != S_IDLE && t_rp > TW'(1)) |=> (st_q[$past(ba)] == S_PRE));

  assert_refresh_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (dev_q == D_REF) |-> (bank_state == '0));
endmodule

// File: tb/sdram_bank_monitor_tb.sv
`timescale 1ns/1ps
module sdram_bank_monitor_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = '0;
  logic [7:0] t_rp = 8'd3, t_rcd = 8'd2, t_rfc = 8'd5, t_mrd = 8'd2, burst_len = 8'd4;
  logic [11:0] bank_state;
  logic [1:0] dev_state, err_bank;
  logic err;
  logic [2:0] err_code;

  localparam logic [2:0] K_NOP = 3'b111, K_ACT = 3'b011, K_RD = 3'b101, K_WR = 3'b100,
                         K_BST = 3'b110, K_PRE = 3'b010, K_REF = 3'b001, K_LMR = 3'b000;

  int n_tot = 0, n_fail = 0;
  bit done = 0;
  logic [4:0] expq[$];
  string tagq[$];

  sdram_bank_monitor u_dut (.clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .t_rp(t_rp), .t_rcd(t_rcd), .t_rfc(t_rfc), .t_mrd(t_mrd),
    .burst_len(burst_len), .bank_state(bank_state), .dev_state(dev_state), .err(err),
    .err_bank(err_bank), .err_code(err_code));

  always #4 clk = ~clk;

  task automatic issue(input logic c, input logic [2:0] rcw, input logic [1:0] b, input logic ap,
                       input logic [2:0] ec, input logic [1:0] eb, input string tag);
    @(negedge clk);
    cs_n = c; {ras_n, cas_n, we_n} = rcw; ba = b; a10 = ap;
    expq.push_back({ec, eb});
    tagq.push_back(tag);
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) issue(1'b0, K_NOP, 2'd0, 1'b0, 3'd0, 2'd0, "R1");
  endtask

  task automatic chk_bank(input int b, input logic [2:0] exp, input string tag);
    n_tot++;
    if (bank_state[3*b +: 3] !== exp) begin
      n_fail++;
      $display("FAIL %s bank%0d state actual=%0d expected=%0d", tag, b, bank_state[3*b +: 3], exp);
    end
  endtask

  task automatic chk_dev(input logic [1:0] exp, input string tag);
    n_tot++;
    if (dev_state !== exp) begin
      n_fail++;
      $display("FAIL %s dev_state actual=%0d expected=%0d", tag, dev_state, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [4:0] it;
    string tg;
    if (!rst && expq.size() > 0) begin
      it = expq.pop_front();
      tg = tagq.pop_front();
      #2;
      n_tot++;
      if (err !== (it[4:2] != 3'd0) || err_code !== it[4:2] ||
          (it[4:2] != 3'd0 && err_bank !== it[1:0])) begin
        n_fail++;
        $display("FAIL %s err/code/bank actual=%0b/%0d/%0d expected=%0b/%0d/%0d", tg,
                 err, err_code, err_bank, it[4:2] != 3'd0, it[4:2], it[1:0]);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_tot++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    n_tot++;
    if (bank_state !== 12'd0 || dev_state !== 2'd0 || err !== 1'b0 || err_code !== 3'd0) begin
      n_fail++;
      $display("FAIL R12 reset state actual=%h/%0d/%0b expected=0/0/0", bank_state, dev_state, err);
    end
    rst = 1'b0;

    issue(0, K_ACT, 0, 0, 0, 0, "R2");
    nop(1); chk_bank(0, 3'd1, "R2");
    nop(1); chk_bank(0, 3'd2, "R2");

    issue(0, K_ACT, 1, 0, 0, 0, "R2");
    issue(0, K_RD, 1, 0, 3'd2, 1, "R7");
    nop(1); chk_bank(1, 3'd2, "R11");
    issue(0, K_ACT, 0, 0, 3'd5, 0, "R2");

    issue(0, K_RD, 0, 0, 0, 0, "R3");
    nop(1); chk_bank(0, 3'd3, "R3");
    nop(2); chk_bank(0, 3'd3, "R3");
    nop(1); chk_bank(0, 3'd2, "R3");

    issue(0, K_WR, 1, 0, 0, 0, "R3");
    issue(0, K_BST, 1, 0, 0, 0, "R6");
    nop(1); chk_bank(1, 3'd2, "R6");
    issue(0, K_BST, 1, 0, 3'd6, 1, "R6");
    issue(0, K_RD, 2, 0, 3'd4, 2, "R3");
    issue(0, K_WR, 3, 0, 3'd4, 3, "R3");

    issue(0, K_PRE, 2, 0, 0, 0, "R5");
    nop(1); chk_bank(2, 3'd0, "R5");

    issue(0, K_PRE, 1, 0, 0, 0, "R5");
    issue(0, K_WR, 0, 1, 0, 0, "R4");
    nop(1); chk_bank(1, 3'd5, "R5"); chk_bank(0, 3'd7, "R4");
    issue(0, K_ACT, 0, 0, 3'd2, 0, "R7");
    chk_bank(1, 3'd0, "R5"); chk_bank(0, 3'd7, "R7");
    nop(4); chk_bank(0, 3'd7, "R4");
    nop(1); chk_bank(0, 3'd0, "R4");

    issue(0, K_ACT, 3, 0, 0, 0, "R2");
    nop(1);
    issue(0, K_REF, 0, 0, 3'd3, 3, "R8");
    issue(0, K_LMR, 1, 0, 3'd3, 3, "R8");
    issue(0, K_PRE, 0, 1, 0, 0, "R9");
    issue(0, K_ACT, 0, 0, 3'd1, 0, "R10");
    nop(1); chk_dev(2'd3, "R9"); chk_bank(3, 3'd0, "R9");
    nop(1); chk_dev(2'd0, "R9"); chk_bank(0, 3'd0, "R11");

    issue(0, K_REF, 0, 0, 0, 0, "R8");
    nop(1); chk_dev(2'd1, "R8");
    issue(0, K_LMR, 1, 0, 3'd1, 1, "R10");
    nop(2); chk_dev(2'd1, "R8");
    nop(1); chk_dev(2'd0, "R8");

    issue(0, K_LMR, 0, 0, 0, 0, "R8");
    nop(1); chk_dev(2'd2, "R8");
    nop(1); chk_dev(2'd0, "R8");

    issue(0, K_ACT, 2, 0, 0, 0, "R2");
    issue(0, K_PRE, 0, 1, 3'd2, 2, "R9");
    nop(1); chk_bank(2, 3'd2, "R9");

    issue(1, K_LMR, 2, 1, 0, 0, "R1");
    nop(1); chk_bank(2, 3'd2, "R1"); chk_dev(2'd0, "R1");

    issue(0, K_RD, 2, 1, 0, 0, "R4");
    nop(1); chk_bank(2, 3'd6, "R4");

    nop(3);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule